// File: doc/BRIEF.md
# Direct and indexed operand fetch unit

This block is the control sequencer of a small 8-bit accumulator machine. It reads two-byte instructions from a byte-wide program memory with synchronous read. For each instruction it forms a source address and reads one operand. The address is either the second byte taken as is, or the X register plus that byte taken as a signed offset. The operand comes from one of two separate data spaces, data RAM or I/O registers, and the opcode picks which one. The result is written into the accumulator A or into X.

Each instruction takes exactly four clock cycles: opcode fetch, argument fetch, operand read and writeback. The surrounding memories are external and answer one cycle after the address is presented. An opcode outside the supported set stops the machine until the next synchronous reset.

Top module: `opf_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `pc`, `acc` and `xreg` equal to 0, `carry` equal to 0, `illegal` equal to 0, and a fresh opcode fetch from address 0.
- R2: Opcode 0x02 adds the RAM byte at the address given by the second byte to A. A takes the low 8 bits of the sum and `carry` takes bit 8.
- R3: Opcode 0x03 adds the RAM byte at X plus the second byte to A. A takes the low 8 bits of the sum and `carry` takes bit 8.
- R4: Opcode 0x5D loads A from the register-space byte at the address in the second byte. RAM is not read, and `carry` and X are unchanged.
- R5: Opcode 0x59 loads X from the RAM byte at X plus the second byte. A and `carry` are unchanged.
- R6: Every legal instruction takes four cycles. `retire` is high for exactly one of them, the last. `pc` grows by 2 modulo 256 after each one.
- R7: Any opcode other than those four sets `illegal` two cycles after its fetch address is presented. From then on `pc`, `acc`, `xreg` and `carry` hold, and no data read strobe rises, until reset.
- R8: In indexed forms the second byte is a signed two's-complement offset. The address wraps modulo 256, so X=0xF0 with offset 0x20 reads address 0x10, and X=0x05 with offset 0xFE reads address 0x03.
- R9: In the operand-read cycle exactly one strobe is high and `data_addr` holds the source address. `reg_rd` is used only for opcode 0x5D and `ram_rd` for the other three. At all other times both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | 8 | Program memory byte address |
| prog_data | input | 8 | Program byte, valid one cycle after `prog_addr` |
| data_addr | output | 8 | Source address for RAM or register space |
| ram_rd | output | 1 | Read strobe for data RAM |
| reg_rd | output | 1 | Read strobe for register space |
| ram_data | input | 8 | RAM byte, valid one cycle after `ram_rd` |
| reg_data | input | 8 | Register byte, valid one cycle after `reg_rd` |
| acc | output | 8 | Accumulator A |
| xreg | output | 8 | Index register X |
| carry | output | 1 | Carry flag |
| pc | output | 8 | Program counter |
| retire | output | 1 | High in the writeback cycle of each instruction |
| illegal | output | 1 | Sticky undefined-opcode indicator |

## Verification
The hardest case to reach is an indexed address that wraps in either direction. It needs a particular X value, and X can only be loaded through an earlier indexed MOV, which itself depends on RAM contents and on the X value before it. A directed prologue plants the required RAM bytes so that one MOV X sets X to 0xF0 and a later one sets it to 0x05. Each is followed by an indexed ADD with a positive or negative offset. Random programs then chain many MOV X operations so that X wanders over the whole range, and the halt case is placed at the end of the directed program.

// File: rtl/opf_pkg.sv
package opf_pkg;

   typedef enum logic [2:0] {
      ST_FETCH_OP  = 3'd0,
      ST_FETCH_ARG = 3'd1,
      ST_READ_MEM  = 3'd2,
      ST_WRITEBACK = 3'd3,
      ST_HALT      = 3'd4
   } opf_state_e;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_ADD_DIR   = 8'h02;
   localparam logic [OPC_W-1:0] OPC_ADD_IDX   = 8'h03;
   localparam logic [OPC_W-1:0] OPC_MOV_X_IDX = 8'h59;
   localparam logic [OPC_W-1:0] OPC_MOV_A_REG = 8'h5D;

   typedef struct packed {
      logic legal;
      logic indexed;
      logic from_reg;
      logic to_x;
      logic add;
   } opf_ctl_t;

endpackage

// File: rtl/opf_decode.sv
module opf_decode
   import opf_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] opc,
   output opf_ctl_t      ctl
);

   logic hi_clear;

   generate
      if (DW > OPC_W) begin : g_wide
         assign hi_clear = ~|opc[DW-1:OPC_W];
      end else begin : g_exact
         assign hi_clear = 1'b1;
      end
   endgenerate

   always_comb begin
      ctl = '0;
      if (hi_clear) begin
         unique case (opc[OPC_W-1:0])
            OPC_ADD_DIR: begin
               ctl.legal = 1'b1;
               ctl.add   = 1'b1;
            end
            OPC_ADD_IDX: begin
               ctl.legal   = 1'b1;
               ctl.add     = 1'b1;
               ctl.indexed = 1'b1;
            end
            OPC_MOV_A_REG: begin
               ctl.legal    = 1'b1;
               ctl.from_reg = 1'b1;
            end
            OPC_MOV_X_IDX: begin
               ctl.legal   = 1'b1;
               ctl.indexed = 1'b1;
               ctl.to_x    = 1'b1;
            end
            default: ctl = '0;
         endcase
      end
   end

endmodule

// File: rtl/opf_addr_gen.sv
module opf_addr_gen #(
   parameter int DW         = 8,
   parameter int AW         = 8,
   parameter bit SIGNED_OFS = 1'b1
) (
   input  logic [DW-1:0] arg,
   input  logic [DW-1:0] xval,
   input  logic          indexed,
   output logic [AW-1:0] addr
);

   localparam int SW = (AW > DW) ? AW : DW;

   logic [SW-1:0] arg_ext;
   logic [SW-1:0] x_ext;
   logic [SW-1:0] sum;

   generate
      if (SIGNED_OFS) begin : g_sext
         assign arg_ext = SW'($signed(arg));
      end else begin : g_zext
         assign arg_ext = SW'(arg);
      end
   endgenerate

   assign x_ext = SW'(xval);
   assign sum   = x_ext + arg_ext;

   always_comb begin
      if (indexed) addr = sum[AW-1:0];
      else         addr = AW'(arg);
   end

endmodule

// File: rtl/opf_exec.sv
module opf_exec
   import opf_pkg::*;
#(
   parameter int DW = 8
) (
   input  opf_ctl_t      ctl,
   input  logic [DW-1:0] acc_cur,
   input  logic [DW-1:0] x_cur,
   input  logic          c_cur,
   input  logic [DW-1:0] operand,
   output logic [DW-1:0] acc_nx,
   output logic [DW-1:0] x_nx,
   output logic          c_nx
);

   logic [DW:0] sum;

   assign sum = {1'b0, acc_cur} + {1'b0, operand};

   always_comb begin
      acc_nx = acc_cur;
      x_nx   = x_cur;
      c_nx   = c_cur;
      if (ctl.add) begin
         acc_nx = sum[DW-1:0];
         c_nx   = sum[DW];
      end else if (ctl.to_x) begin
         x_nx = operand;
      end else begin
         acc_nx = operand;
      end
   end

endmodule

// File: rtl/opf_seq.sv
module opf_seq
   import opf_pkg::*;
#(
   parameter int DW         = 8,
   parameter int AW         = 8,
   parameter int PCW        = 8,
   parameter bit SIGNED_OFS = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   output logic [PCW-1:0] prog_addr,
   input  logic [DW-1:0]  prog_data,
   output logic [AW-1:0]  data_addr,
   output logic           ram_rd,
   output logic           reg_rd,
   input  logic [DW-1:0]  ram_data,
   input  logic [DW-1:0]  reg_data,
   output logic [DW-1:0]  acc,
   output logic [DW-1:0]  xreg,
   output logic           carry,
   output logic [PCW-1:0] pc,
   output logic           retire,
   output logic           illegal
);

   localparam logic [PCW-1:0] PC_ONE  = PCW'(1);
   localparam logic [PCW-1:0] PC_STEP = PCW'(2);

   generate
      if (DW < OPC_W) begin : g_bad_dw
         $error("opf_seq: DW must be at least the opcode width");
      end
      if (PCW < 2) begin : g_bad_pcw
         $error("opf_seq: PCW must be at least 2");
      end
      if (AW < 1) begin : g_bad_aw
         $error("opf_seq: AW must be positive");
      end
   endgenerate

   opf_state_e     state_q;
   opf_ctl_t       ctl_dec;
   opf_ctl_t       ctl_q;
   logic [DW-1:0]  acc_q, x_q, acc_nx, x_nx;
   logic           c_q, c_nx, ill_q;
   logic [PCW-1:0] pc_q;
   logic [DW-1:0]  operand;

   opf_decode #(.DW(DW)) u_dec (
      .opc (prog_data),
      .ctl (ctl_dec)
   );

   opf_addr_gen #(.DW(DW), .AW(AW), .SIGNED_OFS(SIGNED_OFS)) u_agen (
      .arg     (prog_data),
      .xval    (x_q),
      .indexed (ctl_q.indexed),
      .addr    (data_addr)
   );

   assign operand = ctl_q.from_reg ? reg_data : ram_data;

   opf_exec #(.DW(DW)) u_exec (
      .ctl     (ctl_q),
      .acc_cur (acc_q),
      .x_cur   (x_q),
      .c_cur   (c_q),
      .operand (operand),
      .acc_nx  (acc_nx),
      .x_nx    (x_nx),
      .c_nx    (c_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_FETCH_OP;
         ctl_q   <= '0;
         pc_q    <= '0;
         acc_q   <= '0;
         x_q     <= '0;
         c_q     <= 1'b0;
         ill_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_FETCH_OP: state_q <= ST_FETCH_ARG;
            ST_FETCH_ARG: begin
               ctl_q <= ctl_dec;
               if (ctl_dec.legal) begin
                  state_q <= ST_READ_MEM;
               end else begin
                  state_q <= ST_HALT;
                  ill_q   <= 1'b1;
               end
            end
            ST_READ_MEM: state_q <= ST_WRITEBACK;
            ST_WRITEBACK: begin
               acc_q   <= acc_nx;
               x_q     <= x_nx;
               c_q     <= c_nx;
               pc_q    <= pc_q + PC_STEP;
               state_q <= ST_FETCH_OP;
            end
            ST_HALT: state_q <= ST_HALT;
            default: state_q <= ST_HALT;
         endcase
      end
   end

   assign prog_addr = (state_q == ST_FETCH_ARG) ? (pc_q + PC_ONE) : pc_q;
   assign ram_rd    = (state_q == ST_READ_MEM) && !ctl_q.from_reg;
   assign reg_rd    = (state_q == ST_READ_MEM) &&  ctl_q.from_reg;
   assign retire    = (state_q == ST_WRITEBACK);
   assign acc       = acc_q;
   assign xreg      = x_q;
   assign carry     = c_q;
   assign pc        = pc_q;
   assign illegal   = ill_q;

endmodule

// File: rtl/opf_seq_chk.sv
module opf_seq_chk #(
   parameter int DW  = 8,
   parameter int PCW = 8
) (
   input logic           clk,
   input logic           rst,
   input logic [PCW-1:0] pc,
   input logic [DW-1:0]  acc,
   input logic [DW-1:0]  xreg,
   input logic           carry,
   input logic           ram_rd,
   input logic           reg_rd,
   input logic           retire,
   input logic           illegal
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (pc == '0 && acc == '0 && xreg == '0 && !carry && !illegal));

   // R9
   one_space_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ram_rd, reg_rd}));

   // R9
   read_then_retire_chk: assert property (@(posedge clk) disable iff (rst)
      (ram_rd || reg_rd) |=> retire);

   // R6
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      retire |=> (pc == $past(pc) + PCW'(2)));

   // R6
   retire_gap_chk: assert property (@(posedge clk) disable iff (rst)
      retire |=> !retire);

   // R7
   halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      illegal |=> (illegal && $stable(pc) && $stable(acc) && $stable(xreg)
                   && $stable(carry) && !ram_rd && !reg_rd));

   // R4
   reg_carry_chk: assert property (@(posedge clk) disable iff (rst)
      reg_rd |=> ##1 (carry == $past(carry, 2) && xreg == $past(xreg, 2)));

endmodule

bind opf_seq opf_seq_chk #(.DW(DW), .PCW(PCW)) u_opf_seq_chk (
   .clk     (clk),
   .rst     (rst),
   .pc      (pc),
   .acc     (acc),
   .xreg    (xreg),
   .carry   (carry),
   .ram_rd  (ram_rd),
   .reg_rd  (reg_rd),
   .retire  (retire),
   .illegal (illegal)
);

// File: tb/opf_seq_bench.sv
module opf_seq_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] prog_addr, prog_data, data_addr, ram_data, reg_data;
   logic       ram_rd, reg_rd, carry, retire, illegal;
   logic [7:0] acc, xreg, pc;

   logic [7:0] prog_mem [256];
   logic [7:0] ram_mem  [256];
   logic [7:0] reg_mem  [256];

   int n_chk  = 0;
   int n_fail = 0;

   logic [7:0] m_pc, m_a, m_x;
   logic       m_c;

   always #4 clk = ~clk;

   opf_seq u_opf_seq (
      .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_data(prog_data),
      .data_addr(data_addr), .ram_rd(ram_rd), .reg_rd(reg_rd),
      .ram_data(ram_data), .reg_data(reg_data), .acc(acc), .xreg(xreg),
      .carry(carry), .pc(pc), .retire(retire), .illegal(illegal)
   );

   always_ff @(posedge clk) begin
      prog_data <= prog_mem[prog_addr];
      ram_data  <= ram_mem[data_addr];
      reg_data  <= reg_mem[data_addr];
   end

   function automatic bit is_legal(input logic [7:0] op);
      return op == 8'h02 || op == 8'h03 || op == 8'h59 || op == 8'h5D;
   endfunction

   function automatic logic [7:0] src_addr(input logic [7:0] op, input logic [7:0] arg,
                                           input logic [7:0] xv);
      if (op == 8'h03 || op == 8'h59) return 8'(int'(xv) + int'($signed(arg)));
      return arg;
   endfunction

   function automatic string op_req(input logic [7:0] op);
      case (op)
         8'h02:   return "R2";
         8'h03:   return "R3";
         8'h5D:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_pc = 8'h00; m_a = 8'h00; m_x = 8'h00; m_c = 1'b0;
      // R1: reset state, fetch from address 0
      chk("R1 pc", 32'(pc), 0);
      chk("R1 acc", 32'(acc), 0);
      chk("R1 xreg", 32'(xreg), 0);
      chk("R1 carry", 32'(carry), 0);
      chk("R1 illegal", 32'(illegal), 0);
      chk("R1 prog_addr", 32'(prog_addr), 0);
   endtask

   // Starts at the negedge of a fetch cycle; returns 1 if the machine halted.
   task automatic step_one(output bit halted);
      logic [7:0] op, arg, sa, opnd;
      logic [8:0] s;
      string      rq;
      halted = 1'b0;
      op  = prog_mem[m_pc];
      arg = prog_mem[8'(m_pc + 8'd1)];
      @(negedge clk);
      @(negedge clk);
      if (!is_legal(op)) begin
         // R7: halt on undefined opcode
         chk("R7 illegal set", 32'(illegal), 1);
         for (int k = 0; k < 8; k++) begin
            chk("R7 pc hold", 32'(pc), 32'(m_pc));
            chk("R7 acc hold", 32'({acc, xreg, 7'd0, carry}), 32'({m_a, m_x, 7'd0, m_c}));
            chk("R7 no strobe", 32'({ram_rd, reg_rd}), 0);
            @(negedge clk);
         end
         chk("R7 illegal sticky", 32'(illegal), 1);
         halted = 1'b1;
         return;
      end
      rq = op_req(op);
      sa = src_addr(op, arg, m_x);
      // R9: strobe selection and address
      chk("R9 ram_rd", 32'(ram_rd), 32'(op != 8'h5D));
      chk("R9 reg_rd", 32'(reg_rd), 32'(op == 8'h5D));
      if (op == 8'h03 || op == 8'h59) chk("R8 indexed data_addr", 32'(data_addr), 32'(sa));
      else                            chk("R9 direct data_addr", 32'(data_addr), 32'(sa));
      @(negedge clk);
      // R6: retire in fourth cycle
      chk("R6 retire", 32'(retire), 1);
      opnd = (op == 8'h5D) ? reg_mem[sa] : ram_mem[sa];
      case (op)
         8'h02, 8'h03: begin
            s = {1'b0, m_a} + {1'b0, opnd};
            m_a = s[7:0];
            m_c = s[8];
         end
         8'h5D:   m_a = opnd;
         default: m_x = opnd;
      endcase
      m_pc = m_pc + 8'd2;
      @(negedge clk);
      chk({rq, " acc"}, 32'(acc), 32'(m_a));
      chk({rq, " xreg"}, 32'(xreg), 32'(m_x));
      chk({rq, " carry"}, 32'(carry), 32'(m_c));
      chk("R6 pc", 32'(pc), 32'(m_pc));
      chk("R6 no retire", 32'(retire), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      bit h;
      logic [7:0] ops [4];
      ops[0] = 8'h02; ops[1] = 8'h03; ops[2] = 8'h59; ops[3] = 8'h5D;
      void'($urandom(32'h0F5E_0D17));

      // Directed: wrap of indexed addresses, carry, register space, halt
      for (int i = 0; i < 256; i++) begin
         prog_mem[i] = 8'h00;
         ram_mem[i]  = 8'(i * 7 + 3);
         reg_mem[i]  = 8'(i ^ 8'hA5);
      end
      ram_mem[8'h00] = 8'hF0;
      ram_mem[8'h10] = 8'h33;
      ram_mem[8'hEE] = 8'h05;
      ram_mem[8'h03] = 8'hE0;
      ram_mem[8'h40] = 8'h77;
      reg_mem[8'h40] = 8'h11;
      prog_mem[0]  = 8'h59; prog_mem[1]  = 8'h00;  // X = F0
      prog_mem[2]  = 8'h03; prog_mem[3]  = 8'h20;  // R8 up-wrap -> 0x10
      prog_mem[4]  = 8'h59; prog_mem[5]  = 8'hFE;  // X = RAM[EE] = 05
      prog_mem[6]  = 8'h03; prog_mem[7]  = 8'hFE;  // R8 down -> 0x03, carry
      prog_mem[8]  = 8'h5D; prog_mem[9]  = 8'h40;  // R4 reg space, carry kept
      prog_mem[10] = 8'h02; prog_mem[11] = 8'h40;  // R2
      prog_mem[12] = 8'hFF; prog_mem[13] = 8'h00;  // R7
      do_reset();
      for (int i = 0; i < 8; i++) begin
         step_one(h);
         if (h) break;
      end
      chk("R7 halted at end", 32'(illegal), 1);

      // Random programs, long enough to wrap the program counter
      for (int pass = 0; pass < 3; pass++) begin
         for (int i = 0; i < 128; i++) begin
            prog_mem[2*i]   = ops[$urandom % 4];
            prog_mem[2*i+1] = 8'($urandom);
         end
         for (int i = 0; i < 256; i++) begin
            ram_mem[i] = 8'($urandom);
            reg_mem[i] = 8'($urandom);
         end
         do_reset();
         for (int i = 0; i < 300; i++) begin
            step_one(h);
            if (h) break;
         end
      end

      // Undefined opcode after a few random instructions
      prog_mem[20] = 8'h04;
      do_reset();
      for (int i = 0; i < 20; i++) begin
         step_one(h);
         if (h) break;
      end
      chk("R7 halt reached", 32'(illegal), 1);
      do_reset();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule